// File: doc/BRIEF.md
# Serial Display Register-Write Master

This block turns parallel register-write requests into framed transfers on a three-wire serial link to a display driver chip. The link has an active-low chip-select, a serial clock and a serial data output. A host offers an 8-bit register index and a 16-bit value with a valid/ready handshake.

Each write goes out as two frames, each one chip-select period long. Every frame carries 24 bits: a command byte, then a 16-bit payload sent upper byte first. The index frame uses command 0x70 and carries the register number, zero-extended to 16 bits. The data frame uses command 0x72 and carries the value. A request can also ask for the index frame alone. The usual use of this is index 0x22, which puts the driver into its RAM-write mode.

A programmable divider sets how many system clocks each serial clock phase lasts. A busy output reflects that a request is in flight.

Top module: `serial_reg_writer`

## Requirements
- R1: While no transfer is in progress (after reset and between requests), `ser_cs_n`, `ser_clk` and `ser_dout` are all 1 and `req_ready` is 1.
- R2: For each bit, `ser_clk` falls and `ser_dout` takes the bit value in the same cycle; `ser_clk` then rises. `ser_dout` does not change while `ser_clk` is high and `ser_cs_n` is low, and `ser_clk` only toggles while `ser_cs_n` is low.
- R3: While `ser_cs_n` is low, exactly 24 rising edges of `ser_clk` occur. The bits go out most significant first: bits 23..16 are the command byte, bits 15..8 the upper payload byte and bits 7..0 the lower payload byte.
- R4: A full write sends the index frame {0x70, 0x00, index} and then the data frame {0x72, value}.
- R5: When `req_index_only` is 1 at acceptance, only the index frame is sent and `req_value` has no effect.
- R6: Between the two frames of one write, `ser_cs_n` stays high for at least `div_cfg`+1 system clock cycles.
- R7: `req_ready` goes low in the cycle after a request is accepted (`req_valid` and `req_ready` both 1). It stays low until `ser_cs_n` has returned high after the last frame. `busy` is always the inverse of `req_ready`.
- R8: The chip-select setup phase and every low and high phase of `ser_clk` each last exactly `div_cfg`+1 system clock cycles.
- R9: A synchronous active-low reset (`rst_n` = 0 at a rising clock edge) abandons any transfer and returns the block to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | 8 | Serial phase length minus one, in system clocks; hold stable while busy |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_index | input | 8 | Register index |
| req_value | input | 16 | Register value |
| req_index_only | input | 1 | Send the index frame only |
| busy | output | 1 | A request is in flight |
| ser_cs_n | output | 1 | Serial chip-select, active low |
| ser_clk | output | 1 | Serial clock, receiver samples on rising edge |
| ser_dout | output | 1 | Serial data out |

## Verification
The bench builds the block with its default widths: 8-bit index, 16-bit value, 8-bit divider, and command bytes 0x70 and 0x72. Each request in the vector table sets its own `div_cfg` value between 0 and 4. Setting 0 gives a phase one system clock long, so the bench sees the tightest timing, where every tick is back-to-back. The larger settings show whether phase lengths and the inter-frame gap scale with the divider. Index values 0x00 and 0xFF and values 0x0000, 0xFFFF and 0x8001 test the bit order and the zero extension at both ends of the word.

// File: rtl/srw_pkg.sv
// Package: shared state encodings and default command bytes for the
// serial register-write master.
package srw_pkg;

    // Default command byte for a frame that carries a register index
    localparam logic [7:0] CMD_INDEX_DEF = 8'h70;
    // Default command byte for a frame that carries a register value
    localparam logic [7:0] CMD_DATA_DEF  = 8'h72;

    // Frame engine phases
    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_SETUP = 3'd1,
        F_LOW   = 3'd2,
        F_HIGH  = 3'd3,
        F_HOLD  = 3'd4,
        F_GAP   = 3'd5
    } frame_state_t;

    // Request sequencer states
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_IDX_GO  = 3'd1,
        S_IDX_RUN = 3'd2,
        S_DAT_GO  = 3'd3,
        S_DAT_RUN = 3'd4
    } seq_state_t;

endpackage

// File: rtl/srw_tick_gen.sv
// Module: srw_tick_gen
// Makes a one-cycle tick every div_cfg+1 clocks while enabled.
// Assumes div_cfg is held stable while en is high. The counter is cleared
// while disabled, so the first tick always comes div_cfg+1 cycles after enable.
module srw_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Terminal count reached (>= tolerates a setting lowered mid-count)
    assign tick = en && (cnt >= div_cfg);

    // Phase counter: clears when idle or on tick, otherwise counts up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_cfg != '0 && $stable(div_cfg)) |=> !tick);

endmodule

// File: rtl/srw_frame_engine.sv
// Module: srw_frame_engine
// Shifts one FRAME_W-bit word out MSB first under an active-low select.
// Each step lasts one tick: select setup, then clock low/high per bit,
// then hold, then a gap with select high. done pulses on the last gap tick.
// Assumes start is only raised while active is low.
module srw_frame_engine #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               active,
    output logic               done,
    output logic               ser_cs_n,
    output logic               ser_clk,
    output logic               ser_dout
);
    import srw_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    frame_state_t       state;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   bit_cnt;

    // Engine is busy whenever it has left idle
    assign active = (state != F_IDLE);
    // Frame plus trailing gap completed
    assign done   = tick && (state == F_GAP);

    // Phase sequencing and serial pin drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= F_IDLE;
            sr       <= '0;
            bit_cnt  <= '0;
            ser_cs_n <= 1'b1;
            ser_clk  <= 1'b1;
            ser_dout <= 1'b1;
        end else begin
            case (state)
                F_IDLE: begin
                    if (start) begin
                        sr       <= frame_in;
                        bit_cnt  <= '0;
                        ser_cs_n <= 1'b0;
                        state    <= F_SETUP;
                    end
                end
                F_SETUP: begin
                    if (tick) begin
                        ser_clk  <= 1'b0;
                        ser_dout <= sr[FRAME_W-1];
                        state    <= F_LOW;
                    end
                end
                F_LOW: begin
                    if (tick) begin
                        ser_clk <= 1'b1;
                        state   <= F_HIGH;
                    end
                end
                F_HIGH: begin
                    if (tick) begin
                        if (bit_cnt == LAST_BIT) begin
                            state <= F_HOLD;
                        end else begin
                            sr       <= sr << 1;
                            bit_cnt  <= bit_cnt + 1'b1;
                            ser_clk  <= 1'b0;
                            ser_dout <= sr[FRAME_W-2];
                            state    <= F_LOW;
                        end
                    end
                end
                F_HOLD: begin
                    if (tick) begin
                        ser_cs_n <= 1'b1;
                        ser_dout <= 1'b1;
                        state    <= F_GAP;
                    end
                end
                F_GAP: begin
                    if (tick) begin
                        state <= F_IDLE;
                    end
                end
                default: begin
                    state <= F_IDLE;
                end
            endcase
        end
    end

    // R1
    idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> (ser_clk && ser_dout));

    // R2
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_cs_n && ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

    // R2
    clk_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_clk) |-> !ser_cs_n);

endmodule

// File: rtl/srw_sequencer.sv
// Module: srw_sequencer
// Accepts one request, then issues the index frame and, unless index-only,
// the data frame. Ready only in idle, so a request is held off until the
// last frame and its trailing gap are complete.
// Assumes eng_done pulses once per started frame.
module srw_sequencer #(
    parameter int             IDX_W     = 8,
    parameter int             VAL_W     = 16,
    parameter int             CMD_W     = 8,
    parameter logic [CMD_W-1:0] CMD_INDEX = 8'h70,
    parameter logic [CMD_W-1:0] CMD_DATA  = 8'h72
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [IDX_W-1:0]       req_index,
    input  logic [VAL_W-1:0]       req_value,
    input  logic                   req_index_only,
    input  logic                   eng_done,
    output logic                   start,
    output logic [CMD_W+VAL_W-1:0] frame
);
    import srw_pkg::*;

    seq_state_t       state;
    logic [IDX_W-1:0] idx_q;
    logic [VAL_W-1:0] val_q;
    logic             only_q;

    // Ready only when nothing is in flight
    assign req_ready = (state == S_IDLE);
    // Launch a frame from either GO state
    assign start = (state == S_IDX_GO) || (state == S_DAT_GO);
    // Select the word for the frame being launched
    assign frame = (state == S_IDX_GO) ? {CMD_INDEX, VAL_W'(idx_q)}
                                       : {CMD_DATA, val_q};

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            val_q  <= '0;
            only_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            idx_q  <= req_index;
            val_q  <= req_value;
            only_q <= req_index_only;
        end
    end

    // Frame ordering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE:    if (req_valid) state <= S_IDX_GO;
                S_IDX_GO:  state <= S_IDX_RUN;
                S_IDX_RUN: if (eng_done) state <= only_q ? S_IDLE : S_DAT_GO;
                S_DAT_GO:  state <= S_DAT_RUN;
                S_DAT_RUN: if (eng_done) state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // R7
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5
    index_only_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDX_RUN && eng_done && only_q) |=> req_ready);

    // R4
    data_follows_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDX_RUN && eng_done && !only_q) |=> start);

endmodule

// File: rtl/serial_reg_writer.sv
// Module: serial_reg_writer (top)
// Register-write master for a three-wire serial display driver link.
// Each request becomes an index frame and an optional data frame, each
// CMD_W+VAL_W bits long, paced by a programmable phase divider.
// Assumes div_cfg is stable while busy.
module serial_reg_writer #(
    parameter int               IDX_W     = 8,
    parameter int               VAL_W     = 16,
    parameter int               CMD_W     = 8,
    parameter int               DIV_W     = 8,
    parameter logic [CMD_W-1:0] CMD_INDEX = srw_pkg::CMD_INDEX_DEF,
    parameter logic [CMD_W-1:0] CMD_DATA  = srw_pkg::CMD_DATA_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_index,
    input  logic [VAL_W-1:0] req_value,
    input  logic             req_index_only,
    output logic             busy,
    output logic             ser_cs_n,
    output logic             ser_clk,
    output logic             ser_dout
);

    localparam int FRAME_W = CMD_W + VAL_W;

    logic               tick;
    logic               eng_active;
    logic               eng_done;
    logic               eng_start;
    logic [FRAME_W-1:0] eng_frame;

    // Busy mirrors the handshake
    assign busy = !req_ready;

    srw_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (eng_active),
        .div_cfg (div_cfg),
        .tick    (tick)
    );

    srw_sequencer #(
        .IDX_W     (IDX_W),
        .VAL_W     (VAL_W),
        .CMD_W     (CMD_W),
        .CMD_INDEX (CMD_INDEX),
        .CMD_DATA  (CMD_DATA)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_index      (req_index),
        .req_value      (req_value),
        .req_index_only (req_index_only),
        .eng_done       (eng_done),
        .start          (eng_start),
        .frame          (eng_frame)
    );

    srw_frame_engine #(
        .FRAME_W (FRAME_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (eng_start),
        .frame_in (eng_frame),
        .active   (eng_active),
        .done     (eng_done),
        .ser_cs_n (ser_cs_n),
        .ser_clk  (ser_clk),
        .ser_dout (ser_dout)
    );

    // R7
    ready_only_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ser_cs_n);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (ser_cs_n && ser_clk && ser_dout && req_ready));

endmodule

// File: tb/sim_serial_reg_writer.sv
module sim_serial_reg_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = 8'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_index = 8'd0;
    logic [15:0] req_value = 16'd0;
    logic        req_index_only = 1'b0;
    logic        busy;
    logic        ser_cs_n;
    logic        ser_clk;
    logic        ser_dout;

    always #5 clk = ~clk;

    serial_reg_writer u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .div_cfg        (div_cfg),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_index      (req_index),
        .req_value      (req_value),
        .req_index_only (req_index_only),
        .busy           (busy),
        .ser_cs_n       (ser_cs_n),
        .ser_clk        (ser_clk),
        .ser_dout       (ser_dout)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Vector: {index_only, div, index, value}
    localparam int NVEC = 7;
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 8'd0, 8'h10, 16'h4444},
        {1'b0, 8'd1, 8'h12, 16'hA5C3},
        {1'b1, 8'd1, 8'h22, 16'h0000},
        {1'b0, 8'd3, 8'hFF, 16'hFFFF},
        {1'b0, 8'd2, 8'h00, 16'h0000},
        {1'b1, 8'd0, 8'h07, 16'h1234},
        {1'b0, 8'd4, 8'h45, 16'h8001}
    };

    // Line monitor state
    int          cyc = 0;
    int          nf = 0;
    logic [23:0] fr [2];
    int          fb [2];
    logic [23:0] sh = '0;
    int          nbits = 0;
    int          edge_cyc = 0;
    int          rise_cyc = 0;
    int          gap1 = 0;
    int          ph_min = 1000000;
    int          ph_max = 0;
    int          rdy_viol = 0;
    int          idle_viol = 0;
    int          dat_viol = 0;
    int          busy_viol = 0;
    logic        p_cs = 1'b1, p_sclk = 1'b1, p_dout = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nf = 0; nbits = 0; sh = '0; gap1 = 0;
        ph_min = 1000000; ph_max = 0;
        rdy_viol = 0; idle_viol = 0; dat_viol = 0; busy_viol = 0;
        fr[0] = '0; fr[1] = '0; fb[0] = 0; fb[1] = 0;
    endtask

    // Observe serial lines away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !ser_cs_n) begin
                if (nf == 1) gap1 = cyc - rise_cyc;
                sh = '0; nbits = 0; edge_cyc = cyc;
            end
            if (!ser_cs_n && ser_clk != p_sclk) begin
                if (cyc - edge_cyc < ph_min) ph_min = cyc - edge_cyc;
                if (cyc - edge_cyc > ph_max) ph_max = cyc - edge_cyc;
                edge_cyc = cyc;
                if (ser_clk) begin
                    sh = {sh[22:0], ser_dout};
                    nbits++;
                end
            end
            if (!p_cs && ser_cs_n) begin
                if (nf < 2) begin fr[nf] = sh; fb[nf] = nbits; end
                nf++;
                rise_cyc = cyc;
            end
            if (!ser_cs_n && req_ready) rdy_viol++;
            if (ser_cs_n && (!ser_clk || !ser_dout)) idle_viol++;
            if (!ser_cs_n && ser_clk && p_sclk && ser_dout != p_dout) dat_viol++;
            if (ser_cs_n && ser_clk != p_sclk) dat_viol++;
            if (busy == req_ready) busy_viol++;
        end
        p_cs = ser_cs_n; p_sclk = ser_clk; p_dout = ser_dout;
    end

    task automatic do_write(input bit only, input logic [7:0] d,
                            input logic [7:0] idx, input logic [15:0] val);
        int wd;
        @(negedge clk);
        #1;
        clear_mon();
        div_cfg = d;
        req_index = idx; req_value = val; req_index_only = only;
        req_valid = 1'b1;
        @(negedge clk);
        #1;
        // R7: ready falls the cycle after acceptance
        chk(req_ready == 1'b0 && busy == 1'b1, "R7", "ready after accept",
            {busy, req_ready}, 2'b10);
        req_valid = 1'b0;
        wd = 0;
        while (!req_ready && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        #2;
        chk(nf == (only ? 1 : 2), only ? "R5" : "R4", "frame count", nf, only ? 1 : 2);
        chk(fb[0] == 24, "R3", "bits in index frame", fb[0], 24);
        chk(fr[0] == {8'h70, 8'h00, idx}, "R4", "index frame word", fr[0],
            {8'h70, 8'h00, idx});
        if (!only) begin
            chk(fb[1] == 24, "R3", "bits in data frame", fb[1], 24);
            chk(fr[1] == {8'h72, val}, "R4", "data frame word", fr[1], {8'h72, val});
            chk(gap1 >= int'(d) + 1, "R6", "select gap", gap1, int'(d) + 1);
        end
        chk(ph_min == int'(d) + 1 && ph_max == int'(d) + 1, "R8", "phase length",
            ph_max, int'(d) + 1);
        chk(dat_viol == 0, "R2", "data or clock moved illegally", dat_viol, 0);
        chk(rdy_viol == 0 && busy_viol == 0, "R7", "ready while selected", rdy_viol, 0);
        chk(idle_viol == 0 && ser_cs_n && ser_clk && ser_dout && req_ready, "R1",
            "idle levels", idle_viol, 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 / R1: lines idle during reset
        chk(ser_cs_n && ser_clk && ser_dout && req_ready && !busy, "R9",
            "reset state", {ser_cs_n, ser_clk, ser_dout, req_ready}, 4'hF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ser_cs_n && ser_clk && ser_dout && req_ready, "R1", "idle after reset",
            {ser_cs_n, ser_clk, ser_dout, req_ready}, 4'hF);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]);
        end

        // R9: reset in the middle of a frame
        @(negedge clk);
        div_cfg = 8'd3; req_index = 8'h5A; req_value = 16'h0F0F;
        req_index_only = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        chk(ser_cs_n == 1'b0, "R9", "transfer under way before reset", ser_cs_n, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ser_cs_n && ser_clk && ser_dout && req_ready, "R9", "idle after mid-frame reset",
            {ser_cs_n, ser_clk, ser_dout, req_ready}, 4'hF);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(ser_cs_n && req_ready, "R9", "stays idle after release",
            {ser_cs_n, req_ready}, 2'b11);

        // Recovery write after reset
        do_write(1'b0, 8'd0, 8'h81, 16'h7E01);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule